// File: doc/BRIEF.md
# Cache-Block Coherence Invariant Monitor

This block watches, every clock cycle, the access rights that each core holds on each of a small number of tracked cache blocks. It also watches the values the cores report they have read and the writes they report they have committed. It never drives the memory system. Its one job is to flag the first cycle in which the invariants that make private caches invisible are broken. The first invariant allows either exactly one core that may write a block, or any number of cores, possibly none, that may only read it. The second requires every read to return the value left by the most recent write. Rights are tracked per whole block, never per byte.

For each block the monitor keeps a shadow copy of the last committed value. A write commit updates the shadow copy only when it comes from the core that currently holds write permission on that block. Every read observation is compared against the copy. Because all readers in a read-only period compare against the same copy, they are all forced to agree with each other. When a violation is seen, a sticky flag rises together with a code and the offending block and core. All four hold until reset. The read and write observation inputs are valid-only streams. The monitor has no ready signal and never applies back-pressure: every beat presented with valid high is consumed in that cycle.

Top module: `coherence_monitor`

## Requirements
- R1: The permission of core c on block b is the 2-bit field at bits [(c*NBLK+b)*2 +: 2] of `perm_i`. 2'b00 means none, 2'b01 read-only and 2'b10 read-write. The value 2'b11 is treated as none.
- R2: If two or more cores hold read-write on one block in a cycle, the monitor raises error code 1. The reported core is the lowest-index core holding read-write on that block.
- R3: If exactly one core holds read-write on a block and another core holds read-only on it in the same cycle, the monitor raises error code 2. The reported core is the lowest-index read-only holder.
- R4: Any number of read-only holders on a block, including zero, with no read-write holder raises no error.
- R5: Each block's shadow value resets to 0. A write commit from a core that holds read-write on the addressed block in that cycle replaces the shadow value at the end of the cycle. If several such commits target the same block, the lowest-index core wins.
- R6: A write commit from a core without read-write permission on the addressed block has no effect on the shadow value.
- R7: A valid read whose data differs from the block's shadow value raises error code 3. The comparison uses the value from before any write committed in the same cycle. The reported core is the lowest-index mismatching core, and the reported block is that core's read block.
- R8: The error flag, code, block and core register on the clock edge that ends the violating cycle. They then hold until reset, and later violations do not change them.
- R9: When several violations occur in one cycle, code 1 beats code 2, and code 2 beats code 3. Among permission violations of the same code, the lowest block index is reported.
- R10: During and right after reset the flag, code, block and core are all zero.
- R11: Read and write observations are accepted in every cycle with no ready signal. A block index must be below NBLK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_i | input | NCORE*NBLK*2 | Per-core, per-block permission fields |
| rd_valid_i | input | NCORE | Read observation valid, one bit per core |
| rd_blk_i | input | NCORE*BW | Block index of each core's read |
| rd_data_i | input | NCORE*DW | Value returned to each core's read |
| wr_valid_i | input | NCORE | Write commit valid, one bit per core |
| wr_blk_i | input | NCORE*BW | Block index of each core's write |
| wr_data_i | input | NCORE*DW | Value committed by each core's write |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 2 | 1 two writers, 2 writer with reader, 3 stale read |
| err_blk_o | output | BW | Block of the first violation |
| err_core_o | output | CW | Core of the first violation |

## Verification
A shadow value that is wrong, or that is updated by the wrong core, only shows at the ports when a later read of that block is checked. It appears as a code-3 flag one edge after that read, or as a missing flag where one is due. The bench therefore follows each commit with reads of both the new value and the old value. A fault in the permission decoding or in the priority logic shows on the very next edge, as a wrong code, block or core. A cycle-by-cycle model compares all four outputs on every clock. Any such fault is therefore reported in the cycle it first becomes visible.

// File: rtl/cohmon_pkg.sv
package cohmon_pkg;
  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b10;

  typedef enum logic [1:0] {
    ERR_NONE          = 2'd0,
    ERR_TWO_WRITERS   = 2'd1,
    ERR_WRITER_READER = 2'd2,
    ERR_STALE_READ    = 2'd3
  } err_code_e;
endpackage

// File: rtl/cohmon_blk_perm.sv
// Decodes the rights all cores hold on one block.
module cohmon_blk_perm
  import cohmon_pkg::*;
#(
  parameter int NCORE = 4,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic [2*NCORE-1:0] blk_perm_i,
  output logic               two_rw_o,
  output logic               rw_ro_o,
  output logic [CW-1:0]      rw_core_o,
  output logic [CW-1:0]      ro_core_o
);
  logic seen_rw, seen_ro, dup_rw;

  always_comb begin
    seen_rw   = 1'b0;
    seen_ro   = 1'b0;
    dup_rw    = 1'b0;
    rw_core_o = '0;
    ro_core_o = '0;
    for (int c = 0; c < NCORE; c++) begin
      if (blk_perm_i[2*c +: 2] == PERM_RW) begin
        if (seen_rw) dup_rw = 1'b1;
        else begin
          seen_rw   = 1'b1;
          rw_core_o = CW'(c);
        end
      end
      if (blk_perm_i[2*c +: 2] == PERM_RO && !seen_ro) begin
        seen_ro   = 1'b1;
        ro_core_o = CW'(c);
      end
    end
    two_rw_o = dup_rw;
    rw_ro_o  = seen_rw && !dup_rw && seen_ro;
  end
endmodule

// File: rtl/cohmon_shadow.sv
// Last committed value of every tracked block.
module cohmon_shadow
  import cohmon_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32,
  parameter logic [DW-1:0] RESET_VAL = '0,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE*NBLK*2-1:0] perm_i,
  input  logic [NCORE-1:0]      wr_valid_i,
  input  logic [NCORE*BW-1:0]   wr_blk_i,
  input  logic [NCORE*DW-1:0]   wr_data_i,
  output logic [NBLK*DW-1:0]    shadow_o
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [DW-1:0] val_q, val_d;

    always_comb begin
      val_d = val_q;
      for (int c = NCORE - 1; c >= 0; c--) begin
        if (wr_valid_i[c] && wr_blk_i[c*BW +: BW] == BW'(b) &&
            perm_i[(c*NBLK+b)*2 +: 2] == PERM_RW)
          val_d = wr_data_i[c*DW +: DW];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) val_q <= RESET_VAL;
      else        val_q <= val_d;
    end

    assign shadow_o[b*DW +: DW] = val_q;
  end
endmodule

// File: rtl/cohmon_rd_cmp.sv
// Compares every core's read against the shadow of its block.
module cohmon_rd_cmp #(
  parameter int NCORE = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic [NCORE-1:0]    rd_valid_i,
  input  logic [NCORE*BW-1:0] rd_blk_i,
  input  logic [NCORE*DW-1:0] rd_data_i,
  input  logic [NBLK*DW-1:0]  shadow_i,
  output logic                bad_o,
  output logic [CW-1:0]       bad_core_o,
  output logic [BW-1:0]       bad_blk_o
);
  always_comb begin
    int base;
    bad_o      = 1'b0;
    bad_core_o = '0;
    bad_blk_o  = '0;
    for (int c = NCORE - 1; c >= 0; c--) begin
      base = int'(rd_blk_i[c*BW +: BW]) * DW;
      if (rd_valid_i[c] && rd_data_i[c*DW +: DW] != shadow_i[base +: DW]) begin
        bad_o      = 1'b1;
        bad_core_o = CW'(c);
        bad_blk_o  = rd_blk_i[c*BW +: BW];
      end
    end
  end
endmodule

// File: rtl/coherence_monitor.sv
module coherence_monitor
  import cohmon_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32,
  parameter logic [DW-1:0] RESET_VAL = '0,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int PW = NCORE * NBLK * 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       perm_i,
  input  logic [NCORE-1:0]    rd_valid_i,
  input  logic [NCORE*BW-1:0] rd_blk_i,
  input  logic [NCORE*DW-1:0] rd_data_i,
  input  logic [NCORE-1:0]    wr_valid_i,
  input  logic [NCORE*BW-1:0] wr_blk_i,
  input  logic [NCORE*DW-1:0] wr_data_i,
  output logic                err_o,
  output logic [1:0]          err_code_o,
  output logic [BW-1:0]       err_blk_o,
  output logic [CW-1:0]       err_core_o
);
  logic [2*NCORE-1:0] blk_perm [NBLK];
  logic [NBLK-1:0]    two_rw, rw_ro;
  logic [CW-1:0]      rw_core [NBLK];
  logic [CW-1:0]      ro_core [NBLK];
  logic [NBLK*DW-1:0] shadow;
  logic               rd_bad;
  logic [CW-1:0]      rd_bad_core;
  logic [BW-1:0]      rd_bad_blk;

  for (genvar b = 0; b < NBLK; b++) begin : g_perm
    for (genvar c = 0; c < NCORE; c++) begin : g_gather
      assign blk_perm[b][2*c +: 2] = perm_i[(c*NBLK+b)*2 +: 2];
    end
    cohmon_blk_perm #(.NCORE(NCORE)) u_perm (
      .blk_perm_i (blk_perm[b]),
      .two_rw_o   (two_rw[b]),
      .rw_ro_o    (rw_ro[b]),
      .rw_core_o  (rw_core[b]),
      .ro_core_o  (ro_core[b])
    );
  end

  cohmon_shadow #(.NCORE(NCORE), .NBLK(NBLK), .DW(DW), .RESET_VAL(RESET_VAL)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .perm_i     (perm_i),
    .wr_valid_i (wr_valid_i),
    .wr_blk_i   (wr_blk_i),
    .wr_data_i  (wr_data_i),
    .shadow_o   (shadow)
  );

  cohmon_rd_cmp #(.NCORE(NCORE), .NBLK(NBLK), .DW(DW)) u_rd_cmp (
    .rd_valid_i (rd_valid_i),
    .rd_blk_i   (rd_blk_i),
    .rd_data_i  (rd_data_i),
    .shadow_i   (shadow),
    .bad_o      (rd_bad),
    .bad_core_o (rd_bad_core),
    .bad_blk_o  (rd_bad_blk)
  );

  // Priority: two writers, then writer with reader, then stale read.
  err_code_e     sel_code;
  logic [BW-1:0] sel_blk;
  logic [CW-1:0] sel_core;

  always_comb begin
    sel_code = ERR_NONE;
    sel_blk  = '0;
    sel_core = '0;
    for (int b = NBLK - 1; b >= 0; b--) begin
      if (two_rw[b]) begin
        sel_code = ERR_TWO_WRITERS;
        sel_blk  = BW'(b);
        sel_core = rw_core[b];
      end
    end
    if (sel_code == ERR_NONE) begin
      for (int b = NBLK - 1; b >= 0; b--) begin
        if (rw_ro[b]) begin
          sel_code = ERR_WRITER_READER;
          sel_blk  = BW'(b);
          sel_core = ro_core[b];
        end
      end
    end
    if (sel_code == ERR_NONE && rd_bad) begin
      sel_code = ERR_STALE_READ;
      sel_blk  = rd_bad_blk;
      sel_core = rd_bad_core;
    end
  end

  err_code_e     code_q;
  logic          err_q;
  logic [BW-1:0] blk_q;
  logic [CW-1:0] core_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
      blk_q  <= '0;
      core_q <= '0;
    end else if (!err_q && sel_code != ERR_NONE) begin
      err_q  <= 1'b1;
      code_q <= sel_code;
      blk_q  <= sel_blk;
      core_q <= sel_core;
    end
  end

  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign err_blk_o  = blk_q;
  assign err_core_o = core_q;
endmodule

// File: rtl/coherence_monitor_chk.sv
module coherence_monitor_chk #(
  parameter int NCORE = 4,
  parameter int NBLK  = 8,
  parameter int BW    = 3,
  parameter int CW    = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NCORE*NBLK*2-1:0] perm_i,
  input logic [NCORE-1:0]        rd_valid_i,
  input logic                    err_o,
  input logic [1:0]              err_code_o,
  input logic [BW-1:0]           err_blk_o,
  input logic [CW-1:0]           err_core_o
);
  function automatic logic has_dual_rw(input logic [NCORE*NBLK*2-1:0] p);
    for (int b = 0; b < NBLK; b++) begin
      int n;
      n = 0;
      for (int c = 0; c < NCORE; c++)
        if (p[(c*NBLK+b)*2 +: 2] == 2'b10) n++;
      if (n > 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic has_rw_ro(input logic [NCORE*NBLK*2-1:0] p);
    for (int b = 0; b < NBLK; b++) begin
      int w, r;
      w = 0;
      r = 0;
      for (int c = 0; c < NCORE; c++) begin
        if (p[(c*NBLK+b)*2 +: 2] == 2'b10) w++;
        if (p[(c*NBLK+b)*2 +: 2] == 2'b01) r++;
      end
      if (w == 1 && r > 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  assert_dual_writer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && has_dual_rw(perm_i)) |=> (err_o && err_code_o == 2'd1));

  assert_writer_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && !has_dual_rw(perm_i) && has_rw_ro(perm_i)) |=> (err_o && err_code_o == 2'd2));

  assert_readers_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && !has_dual_rw(perm_i) && !has_rw_ro(perm_i) && rd_valid_i == '0) |=> !err_o);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && $stable(err_code_o) && $stable(err_blk_o) && $stable(err_core_o)));

  assert_clear_detail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_o |-> (err_code_o == 2'd0 && err_blk_o == '0 && err_core_o == '0));

  assert_code_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o != 2'd0));
endmodule

bind coherence_monitor coherence_monitor_chk #(
  .NCORE(NCORE), .NBLK(NBLK), .BW(BW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .perm_i     (perm_i),
  .rd_valid_i (rd_valid_i),
  .err_o      (err_o),
  .err_code_o (err_code_o),
  .err_blk_o  (err_blk_o),
  .err_core_o (err_core_o)
);

// File: tb/tb_coherence_monitor.sv
`timescale 1ns/1ps
module tb_coherence_monitor;
  localparam int NC = 4;
  localparam int NB = 8;
  localparam int DW = 32;
  localparam int BW = 3;
  localparam int CW = 2;
  localparam int PW = NC * NB * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0]    perm;
  logic [NC-1:0]    rd_v, wr_v;
  logic [NC*BW-1:0] rd_b, wr_b;
  logic [NC*DW-1:0] rd_d, wr_d;
  logic             err;
  logic [1:0]       code;
  logic [BW-1:0]    eblk;
  logic [CW-1:0]    ecore;

  always #4 clk = ~clk;

  coherence_monitor dut (
    .clk(clk), .rst_n(rst_n), .perm_i(perm),
    .rd_valid_i(rd_v), .rd_blk_i(rd_b), .rd_data_i(rd_d),
    .wr_valid_i(wr_v), .wr_blk_i(wr_b), .wr_data_i(wr_d),
    .err_o(err), .err_code_o(code), .err_blk_o(eblk), .err_core_o(ecore)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model: expected outputs after the next edge
  bit          m_err;
  int          m_code, m_blk, m_core;
  logic [DW-1:0] m_sh [NB];

  function automatic int pm(int c, int b);
    return int'(perm[(c*NB+b)*2 +: 2]);
  endfunction

  task automatic clear_stim();
    perm = '0; rd_v = '0; wr_v = '0; rd_b = '0; wr_b = '0; rd_d = '0; wr_d = '0;
  endtask

  task automatic set_perm(int c, int b, logic [1:0] v);
    perm[(c*NB+b)*2 +: 2] = v;
  endtask

  task automatic do_rd(int c, int b, logic [DW-1:0] d);
    rd_v[c] = 1'b1; rd_b[c*BW +: BW] = BW'(b); rd_d[c*DW +: DW] = d;
  endtask

  task automatic do_wr(int c, int b, logic [DW-1:0] d);
    wr_v[c] = 1'b1; wr_b[c*BW +: BW] = BW'(b); wr_d[c*DW +: DW] = d;
  endtask

  task automatic model_step();
    logic [DW-1:0] nsh [NB];
    bit found;
    if (!rst_n) begin
      m_err = 0; m_code = 0; m_blk = 0; m_core = 0;
      for (int b = 0; b < NB; b++) m_sh[b] = '0;
      return;
    end
    if (!m_err) begin
      found = 0;
      for (int b = 0; b < NB && !found; b++) begin
        int w; int fw;
        w = 0; fw = -1;
        for (int c = 0; c < NC; c++) if (pm(c, b) == 2) begin w++; if (fw < 0) fw = c; end
        if (w >= 2) begin found = 1; m_code = 1; m_blk = b; m_core = fw; end
      end
      for (int b = 0; b < NB && !found; b++) begin
        int w; int fr;
        w = 0; fr = -1;
        for (int c = 0; c < NC; c++) begin
          if (pm(c, b) == 2) w++;
          if (pm(c, b) == 1 && fr < 0) fr = c;
        end
        if (w == 1 && fr >= 0) begin found = 1; m_code = 2; m_blk = b; m_core = fr; end
      end
      for (int c = 0; c < NC && !found; c++) begin
        int b;
        b = int'(rd_b[c*BW +: BW]);
        if (rd_v[c] && rd_d[c*DW +: DW] !== m_sh[b]) begin
          found = 1; m_code = 3; m_blk = b; m_core = c;
        end
      end
      if (found) m_err = 1;
    end
    for (int b = 0; b < NB; b++) nsh[b] = m_sh[b];
    for (int c = NC - 1; c >= 0; c--) begin
      int b;
      b = int'(wr_b[c*BW +: BW]);
      if (wr_v[c] && pm(c, b) == 2) nsh[b] = wr_d[c*DW +: DW];
    end
    for (int b = 0; b < NB; b++) m_sh[b] = nsh[b];
  endtask

  // Applies current stimulus across one edge, then compares with the model.
  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (err !== m_err || int'(code) != m_code || int'(eblk) != m_blk || int'(ecore) != m_core) begin
      errors++;
      $display("FAIL %s: got err=%0b code=%0d blk=%0d core=%0d, expected err=%0b code=%0d blk=%0d core=%0d",
               tag, err, code, eblk, ecore, m_err, m_code, m_blk, m_core);
    end
  endtask

  // Hand-computed expectation, independent of the model.
  task automatic expect_out(string tag, bit e, int c, int b, int k);
    checks++;
    if (err !== e || int'(code) != c || int'(eblk) != b || int'(ecore) != k) begin
      errors++;
      $display("FAIL %s: got err=%0b code=%0d blk=%0d core=%0d, expected err=%0b code=%0d blk=%0d core=%0d",
               tag, err, code, eblk, ecore, e, c, b, k);
    end
  endtask

  task automatic do_reset();
    clear_stim();
    rst_n = 1'b0;
    tick("R10");
    rst_n = 1'b1;
  endtask

  initial begin
    clear_stim();
    @(negedge clk);
    rst_n = 1'b0;
    tick("R10");
    tick("R10");
    rst_n = 1'b1;
    expect_out("R10", 0, 0, 0, 0);

    // R4: read-only groups with matching reads
    for (int c = 0; c < NC; c++) set_perm(c, 0, 2'b01);
    set_perm(0, 7, 2'b01); set_perm(2, 7, 2'b01);
    for (int c = 0; c < NC; c++) do_rd(c, (c == 2) ? 7 : 0, 32'h0);
    tick("R4");
    clear_stim();
    tick("R4");
    expect_out("R4", 0, 0, 0, 0);

    // R1: 2'b11 counts as no permission
    set_perm(0, 3, 2'b10); set_perm(1, 3, 2'b11); set_perm(2, 3, 2'b11);
    tick("R1");
    expect_out("R1", 0, 0, 0, 0);
    clear_stim();

    // R5: legal commit, then a read-only group sees it
    set_perm(1, 3, 2'b10); do_wr(1, 3, 32'hA5A5_0001);
    tick("R5");
    clear_stim();
    set_perm(0, 3, 2'b01); set_perm(2, 3, 2'b01); set_perm(3, 3, 2'b01);
    do_rd(0, 3, 32'hA5A5_0001); do_rd(2, 3, 32'hA5A5_0001); do_rd(3, 3, 32'hA5A5_0001);
    tick("R5");
    expect_out("R5", 0, 0, 0, 0);
    clear_stim();

    // R7: read in the commit cycle sees the prior value
    set_perm(1, 3, 2'b10); do_rd(1, 3, 32'hA5A5_0001); do_wr(1, 3, 32'h0000_BEEF);
    tick("R7");
    do_rd(1, 3, 32'h0000_BEEF); wr_v = '0;
    tick("R7");
    expect_out("R7", 0, 0, 0, 0);
    clear_stim();

    // R6: commit without write permission is dropped
    do_wr(2, 5, 32'h1234);
    tick("R6");
    clear_stim();
    set_perm(0, 5, 2'b01); do_rd(0, 5, 32'h0);
    tick("R6");
    expect_out("R6", 0, 0, 0, 0);
    clear_stim();

    // R7: stale reads, lowest mismatching core reported
    do_rd(3, 3, 32'hA5A5_0001); do_rd(2, 5, 32'h1234);
    tick("R7");
    expect_out("R7", 1, 3, 5, 2);
    clear_stim();

    // R8: later violation leaves the record alone
    set_perm(0, 0, 2'b10); set_perm(1, 0, 2'b10);
    tick("R8");
    tick("R8");
    expect_out("R8", 1, 3, 5, 2);
    do_reset();
    expect_out("R10", 0, 0, 0, 0);

    // R2: two writers
    set_perm(3, 6, 2'b10); set_perm(1, 6, 2'b10);
    tick("R2");
    expect_out("R2", 1, 1, 6, 1);
    do_reset();

    // R3: writer plus readers
    set_perm(2, 2, 2'b10); set_perm(0, 2, 2'b01); set_perm(3, 2, 2'b01);
    tick("R3");
    expect_out("R3", 1, 2, 2, 0);
    do_reset();

    // R9: priority among simultaneous violations
    set_perm(2, 4, 2'b10); set_perm(3, 4, 2'b10);
    set_perm(0, 1, 2'b10); set_perm(1, 1, 2'b01);
    do_rd(0, 0, 32'd99);
    tick("R9");
    expect_out("R9", 1, 1, 4, 2);
    do_reset();
    set_perm(0, 1, 2'b10); set_perm(1, 1, 2'b01);
    do_rd(0, 0, 32'd99);
    tick("R9");
    expect_out("R9", 1, 2, 1, 1);
    do_reset();
    set_perm(0, 5, 2'b10); set_perm(1, 5, 2'b10);
    set_perm(2, 2, 2'b10); set_perm(3, 2, 2'b10);
    tick("R9");
    expect_out("R9", 1, 1, 2, 2);
    do_reset();

    // R11: mixed traffic every cycle, compared against the model
    for (int i = 0; i < 400; i++) begin
      clear_stim();
      if (i % 25 == 24) rst_n = 1'b0;
      for (int b = 0; b < NB; b++) begin
        int mode;
        mode = int'($urandom % 12);
        if (mode < 5) begin
          for (int c = 0; c < NC; c++) if ($urandom % 2 == 0) set_perm(c, b, 2'b01);
        end else if (mode < 10) set_perm(int'($urandom % NC), b, 2'b10);
        else if (mode == 10)
          for (int c = 0; c < NC; c++) set_perm(c, b, 2'($urandom));
      end
      for (int c = 0; c < NC; c++) begin
        int b;
        b = int'($urandom % NB);
        if ($urandom % 2 == 0) do_rd(c, b, ($urandom % 10 == 0) ? $urandom : m_sh[b]);
        if ($urandom % 2 == 0) do_wr(c, int'($urandom % NB), $urandom);
      end
      tick("R11");
      rst_n = 1'b1;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11: watchdog expired, got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule